// File: doc/BRIEF.md
# Down-Counting Compare Timer

This block is a 32-bit programmable interval timer attached to a simple word-addressed register bus. A counter steps down once per prescaled tick. Software picks what happens when the count passes zero: it either starts again from a programmed start value or wraps to all-ones and keeps going. A compare register defines a match point. When the counter lands on that value, a sticky match flag is raised, which can drive an interrupt line and an output pin.

Because the count falls, software schedules an event N ticks ahead by reading the counter and writing `count - N` to the compare register. Arithmetic is modulo 2^32. A free-running 32-bit time base is made by writing all-ones as the start value and enabling the timer with auto-reload off. A control bit arms an immediate copy of the start value into the counter whenever that value is rewritten. Another control bit makes each enable restart the count from the start value.

The bus is a single-cycle interface. A write happens on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr`. Only word-aligned byte offsets are decoded.

Top module: `dcmp_timer`

## Requirements
- R1: After `rst`, control reads 0x0, status reads 0x0, start value reads 0xFFFFFFFF, compare reads 0x0 and counter reads 0x0. Both `irq` and `tmr_pin` are low.
- R2: Offsets: 0x00 control, 0x04 status, 0x08 start value, 0x0C compare, 0x10 counter. Start value and compare read back whatever was written. Control reads back the written word ANDed with 0x03EEFFFF. Control fields: bit 0 run, bit 1 load-on-enable, bit 2 interrupt enable, bit 3 auto-reload, bits 15:4 divider, bit 16 software reset (never stored), bit 17 start-value overwrite, bits 18/19/21 stored low-power run permissions, bits 23:22 pin mode, bits 25:24 clock source.
- R3: While run is 1 and clock source is nonzero, the counter decreases by one every (divider+1) clock cycles. When run is 0 or clock source is 0, the counter holds its value.
- R4: With auto-reload 0, a tick taken at count 0 gives 0xFFFFFFFF.
- R5: With auto-reload 1, a tick taken at count 0 loads the start value.
- R6: A control write that moves run from 0 to 1 with load-on-enable set copies the start value into the counter at that edge. With load-on-enable clear, counting resumes from the held value.
- R7: With start-value overwrite set, a write to the start value also places the written word in the counter at the same edge, and the prescaler restarts.
- R8: Status bit 0 is set by any tick whose new count equals compare. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R9: `irq` is high exactly when status bit 0 and control bit 2 are both 1.
- R10: On a compare event, the pin mode acts on the pin: 1 inverts it, 2 drives it low, 3 drives it high. With mode 0 the pin reads low and its held state is left unchanged.
- R11: A control write with bit 16 set returns every register and the pin to its R1 value at that edge, whatever the rest of the written word holds.
- R12: Writes to the counter offset are ignored. Unaligned or unmapped offsets read 0x0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the count clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Compare interrupt request |
| tmr_pin | output | 1 | Compare-driven output pin |

## Verification
A corrupted prescaler phase or a missed wrap shows up as a counter value that is wrong on the very next read of offset 0x10. An off-by-one in the match logic appears as `irq` or `tmr_pin` changing one tick early or late, and the per-cycle comparison catches it in the cycle it happens. A stale pin state under mode 0 is hidden until the mode changes. That case is reached by toggling the mode after silent matches and then comparing the pin level.

// File: rtl/dct_pkg.sv
package dct_pkg;

    localparam int DIV_W    = 12;
    localparam int SRST_BIT = 16;

    // word indices (byte offset >> 2)
    localparam int IDX_CTRL = 0;
    localparam int IDX_STAT = 1;
    localparam int IDX_LOAD = 2;
    localparam int IDX_CMP  = 3;
    localparam int IDX_CNT  = 4;

    typedef enum logic [1:0] {
        PIN_OFF  = 2'd0,
        PIN_FLIP = 2'd1,
        PIN_LOW  = 2'd2,
        PIN_HIGH = 2'd3
    } pin_mode_e;

    typedef struct packed {
        logic [1:0]       src;
        pin_mode_e        pmode;
        logic             stop_run;
        logic             rsv20;
        logic             wait_run;
        logic             dbg_run;
        logic             ld_ovw;
        logic             soft_rst;
        logic [DIV_W-1:0] div;
        logic             reload;
        logic             cmp_ie;
        logic             ld_on_en;
        logic             run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam logic [CTRL_W-1:0] CTRL_WMASK = CTRL_W'(32'h03EE_FFFF);

    function automatic ctrl_t ctrl_from_word(input logic [CTRL_W-1:0] w);
        return ctrl_t'(w & CTRL_WMASK);
    endfunction

    function automatic logic pin_after_event(input pin_mode_e m, input logic cur);
        case (m)
            PIN_FLIP: return ~cur;
            PIN_LOW:  return 1'b0;
            PIN_HIGH: return 1'b1;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/dct_regs.sv
module dct_regs
    import dct_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              cmp_evt,
    input  logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] cmp_val,
    output logic              flag,
    output logic              active,
    output logic              reload,
    output logic              cmp_ie,
    output logic [DIV_W-1:0]  div,
    output pin_mode_e         pmode,
    output logic              srst,
    output logic              load_now,
    output logic [DATA_W-1:0] load_src
);
    localparam int IDX_W = ADDR_W - 2;

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] cmp_q;
    logic              flag_q;

    logic             aligned;
    logic [IDX_W-1:0] widx;
    logic             wr_any, wr_ctrl, wr_stat, wr_load, wr_cmp;
    logic             en_load, ovw_load;
    ctrl_t            wctrl;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign widx    = bus_addr[ADDR_W-1:2];
    assign wr_any  = bus_sel & bus_wr & aligned;
    assign wr_ctrl = wr_any & (widx == IDX_W'(IDX_CTRL));
    assign wr_stat = wr_any & (widx == IDX_W'(IDX_STAT));
    assign wr_load = wr_any & (widx == IDX_W'(IDX_LOAD));
    assign wr_cmp  = wr_any & (widx == IDX_W'(IDX_CMP));

    assign wctrl    = ctrl_from_word(bus_wdata[CTRL_W-1:0]);
    assign srst     = wr_ctrl & bus_wdata[SRST_BIT];
    assign en_load  = wr_ctrl & ~srst & wctrl.run & wctrl.ld_on_en & ~ctrl_q.run;
    assign ovw_load = wr_load & ctrl_q.ld_ovw;
    assign load_now = en_load | ovw_load;
    assign load_src = ovw_load ? bus_wdata : load_q;

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            ctrl_q <= '0;
            load_q <= '1;
            cmp_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= wctrl;
            if (wr_load) load_q <= bus_wdata;
            if (wr_cmp)  cmp_q  <= bus_wdata;
            if (cmp_evt)                      flag_q <= 1'b1;
            else if (wr_stat && bus_wdata[0]) flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (widx)
                IDX_W'(IDX_CTRL): bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
                IDX_W'(IDX_STAT): bus_rdata = {{(DATA_W-1){1'b0}}, flag_q};
                IDX_W'(IDX_LOAD): bus_rdata = load_q;
                IDX_W'(IDX_CMP):  bus_rdata = cmp_q;
                IDX_W'(IDX_CNT):  bus_rdata = count;
                default:          bus_rdata = '0;
            endcase
        end
    end

    assign load_val = load_q;
    assign cmp_val  = cmp_q;
    assign flag     = flag_q;
    assign active   = ctrl_q.run & (ctrl_q.src != 2'b00);
    assign reload   = ctrl_q.reload;
    assign cmp_ie   = ctrl_q.cmp_ie;
    assign div      = ctrl_q.div;
    assign pmode    = ctrl_q.pmode;

endmodule

// File: rtl/dct_prescaler.sv
module dct_prescaler
    import dct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             active,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;

    // >= keeps a shrunken divider from running the phase past its end
    assign tick = active & (phase_q >= div);

    always_ff @(posedge clk) begin
        if (rst || clr || !active) phase_q <= '0;
        else if (tick)             phase_q <= '0;
        else                       phase_q <= phase_q + 1'b1;
    end

endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              srst,
    input  logic              load_now,
    input  logic [DATA_W-1:0] load_src,
    input  logic              tick,
    input  logic              reload,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] cmp_val,
    output logic [DATA_W-1:0] count,
    output logic              cmp_evt
);
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] next_dec;
    logic              at_zero;

    assign at_zero  = (count_q == '0);
    assign next_dec = at_zero ? (reload ? load_val : '1) : (count_q - 1'b1);
    assign cmp_evt  = tick & ~srst & ~load_now & (next_dec == cmp_val);

    always_ff @(posedge clk) begin
        if (rst || srst)   count_q <= '0;
        else if (load_now) count_q <= load_src;
        else if (tick)     count_q <= next_dec;
    end

    assign count = count_q;

endmodule

// File: rtl/dct_outpin.sv
module dct_outpin
    import dct_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      srst,
    input  logic      cmp_evt,
    input  pin_mode_e pmode,
    output logic      pin_state,
    output logic      pin_out
);
    logic state_q;

    always_ff @(posedge clk) begin
        if (rst || srst)  state_q <= 1'b0;
        else if (cmp_evt) state_q <= pin_after_event(pmode, state_q);
    end

    assign pin_state = state_q;
    assign pin_out   = (pmode == PIN_OFF) ? 1'b0 : state_q;

endmodule

// File: rtl/dcmp_timer.sv
module dcmp_timer
    import dct_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              tmr_pin
);
    logic [DATA_W-1:0] load_val, cmp_val, count, load_src;
    logic              flag, active, reload, cmp_ie, srst, load_now;
    logic              tick, cmp_evt, pin_q;
    logic [DIV_W-1:0]  div;
    pin_mode_e         pmode;

    dct_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cmp_evt(cmp_evt), .count(count),
        .bus_rdata(bus_rdata), .load_val(load_val), .cmp_val(cmp_val),
        .flag(flag), .active(active), .reload(reload), .cmp_ie(cmp_ie),
        .div(div), .pmode(pmode), .srst(srst), .load_now(load_now),
        .load_src(load_src)
    );

    dct_prescaler u_presc (
        .clk(clk), .rst(rst), .clr(srst | load_now),
        .active(active), .div(div), .tick(tick)
    );

    dct_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst(rst), .srst(srst),
        .load_now(load_now), .load_src(load_src), .tick(tick),
        .reload(reload), .load_val(load_val), .cmp_val(cmp_val),
        .count(count), .cmp_evt(cmp_evt)
    );

    dct_outpin u_pin (
        .clk(clk), .rst(rst), .srst(srst), .cmp_evt(cmp_evt),
        .pmode(pmode), .pin_state(pin_q), .pin_out(tmr_pin)
    );

    assign irq = flag & cmp_ie;

endmodule

// File: rtl/dcmp_timer_chk.sv
module dcmp_timer_chk
    import dct_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              load_now,
    input logic              srst,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] load_val,
    input logic              reload,
    input logic              active,
    input logic              cmp_evt,
    input logic              flag,
    input pin_mode_e         pmode,
    input logic              pin_q
);
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!active && !load_now && !srst) |=> $stable(count)); // R3

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_now && !srst && count != '0) |=> (count == $past(count) - 1'b1)); // R3

    AST_WRAP_ONES: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_now && !srst && count == '0 && !reload) |=> (count == '1)); // R4

    AST_RELOAD_START: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_now && !srst && count == '0 && reload) |=> (count == $past(load_val))); // R5

    AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (rst)
        cmp_evt |=> flag); // R8

    AST_PIN_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (cmp_evt && pmode == PIN_FLIP) |=> (pin_q != $past(pin_q))); // R10

    AST_PIN_HIGH: assert property (@(posedge clk) disable iff (rst)
        (cmp_evt && pmode == PIN_HIGH) |=> pin_q); // R10

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        srst |=> (count == '0 && !flag && !pin_q)); // R11

endmodule

bind dcmp_timer dcmp_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .load_now(load_now), .srst(srst),
    .count(count), .load_val(load_val), .reload(reload), .active(active),
    .cmp_evt(cmp_evt), .flag(flag), .pmode(pmode), .pin_q(pin_q)
);

// File: tb/dcmp_timer_tb.sv
`timescale 1ns/100ps
module dcmp_timer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq, tmr_pin;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    dcmp_timer u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tmr_pin(tmr_pin)
    );

    // reference state, derived from the requirements
    logic [31:0] m_ctrl, m_load, m_cmp, m_cnt;
    logic        m_flag, m_pst;
    int unsigned m_pc;
    logic [31:0] last_rd;

    localparam logic [31:0] WMASK = 32'h03EE_FFFF;

    task automatic m_reset();
        m_ctrl = 0; m_load = 32'hFFFF_FFFF; m_cmp = 0; m_cnt = 0;
        m_flag = 0; m_pst = 0; m_pc = 0;
    endtask

    function automatic logic [31:0] m_read(input logic [4:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[4:2])
            3'd0: return m_ctrl;
            3'd1: return {31'b0, m_flag};
            3'd2: return m_load;
            3'd3: return m_cmp;
            3'd4: return m_cnt;
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_step(input logic s, input logic w, input logic [4:0] a, input logic [31:0] d);
        logic wr_, act, tick, enl, ovl, evt;
        logic [2:0]  idx;
        logic [31:0] nxt;
        int unsigned dv;
        wr_ = s && w && (a[1:0] == 2'b00);
        idx = a[4:2];
        if (wr_ && idx == 3'd0 && d[16]) begin
            m_reset();
            return;
        end
        act  = m_ctrl[0] && (m_ctrl[25:24] != 2'b00);
        dv   = m_ctrl[15:4];
        tick = act && (m_pc >= dv);
        enl  = wr_ && idx == 3'd0 && d[0] && d[1] && !m_ctrl[0];
        ovl  = wr_ && idx == 3'd2 && m_ctrl[17];
        evt  = 0;
        if (enl || ovl) begin
            m_cnt = ovl ? d : m_load;
            m_pc  = 0;
        end else begin
            if (tick) begin
                nxt   = (m_cnt == 0) ? (m_ctrl[3] ? m_load : 32'hFFFF_FFFF) : m_cnt - 1;
                evt   = (nxt == m_cmp);
                m_cnt = nxt;
                m_pc  = 0;
            end else begin
                m_pc = act ? m_pc + 1 : 0;
            end
        end
        if (evt) begin
            case (m_ctrl[23:22])
                2'd1: m_pst = ~m_pst;
                2'd2: m_pst = 1'b0;
                2'd3: m_pst = 1'b1;
                default: ;
            endcase
        end
        if (evt) m_flag = 1'b1;
        else if (wr_ && idx == 3'd1 && d[0]) m_flag = 1'b0;
        if (wr_ && idx == 3'd0) m_ctrl = d & WMASK;
        if (wr_ && idx == 3'd2) m_load = d;
        if (wr_ && idx == 3'd3) m_cmp = d;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_cycle(input logic s, input logic w, input logic [4:0] a,
                               input logic [31:0] d, input string tag, input logic do_rd);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        if (do_rd) begin
            last_rd = bus_rdata;
            check(tag, bus_rdata, m_read(a));
        end
        @(posedge clk);
        m_step(s, w, a, d);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        check("R9 irq", {31'b0, irq}, {31'b0, m_flag & m_ctrl[2]});
        check("R10 pin", {31'b0, tmr_pin}, {31'b0, (m_ctrl[23:22] == 2'd0) ? 1'b0 : m_pst});
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        drive_cycle(1, 1, a, d, "", 0);
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        drive_cycle(1, 0, a, 0, tag, 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive_cycle(0, 0, 5'h10, 0, "R3 idle", 1);
    endtask

    // control word builder
    function automatic logic [31:0] cw(input logic run, input logic lde, input logic ie,
                                       input logic rl, input int unsigned dv, input logic ovw,
                                       input logic [1:0] pm, input logic [1:0] src);
        return {6'b0, src, pm, 4'b0, ovw, 1'b0, dv[11:0], rl, ie, lde, run};
    endfunction

    localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_LOAD = 5'h08,
                           A_CMP = 5'h0C, A_CNT = 5'h10;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [4:0]  a;
        void'($urandom(32'd20240611));
        rst = 1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(A_CTRL, "R1 ctrl"); rd(A_STAT, "R1 stat");
        rd(A_LOAD, "R1 load"); check("R1 load literal", last_rd, 32'hFFFF_FFFF);
        rd(A_CMP, "R1 cmp");   rd(A_CNT, "R1 cnt");

        // R2 map and readback
        wr(A_CTRL, 32'hFFFF_FFFE & ~32'h0001_0000);
        rd(A_CTRL, "R2 ctrl mask"); check("R2 ctrl literal", last_rd, 32'h03EE_FFFE);
        wr(A_CTRL, 0);
        wr(A_LOAD, 32'h1234_5678); rd(A_LOAD, "R2 load");
        wr(A_CMP, 32'hCAFE_0001);  rd(A_CMP, "R2 cmp");

        // R12 counter read-only, unmapped offsets
        wr(A_CNT, 32'hDEAD_BEEF); rd(A_CNT, "R12 cnt ro");
        check("R12 cnt literal", last_rd, 32'h0);
        wr(5'h14, 32'h5555_5555); rd(5'h14, "R12 unmapped");
        rd(5'h09, "R12 unaligned");
        wr(5'h0A, 32'h0); rd(A_LOAD, "R12 unaligned write ignored");

        // R3 + R6: enable with load-on-enable, divider 3
        wr(A_LOAD, 100);
        wr(A_CTRL, cw(1, 1, 0, 0, 3, 0, 0, 2'd1));
        for (int i = 0; i < 12; i++) rd(A_CNT, "R3 divide");
        check("R3 after 12 cyc", last_rd, 32'd98);
        wr(A_CTRL, cw(1, 1, 0, 0, 3, 0, 0, 2'd0));   // source off: hold
        idle(6);
        wr(A_CTRL, cw(0, 0, 0, 0, 0, 0, 0, 2'd1));   // stop
        wr(A_CTRL, cw(1, 0, 0, 0, 0, 0, 0, 2'd1));   // R6 resume without load
        rd(A_CNT, "R6 resume");
        wr(A_CTRL, cw(0, 0, 0, 0, 0, 0, 0, 2'd1));
        wr(A_CTRL, cw(1, 1, 0, 0, 0, 0, 0, 2'd1));   // R6 reload on enable
        rd(A_CNT, "R6 load on enable"); check("R6 literal", last_rd, 32'd100);

        // R7 + R4 free-run wrap
        wr(A_CTRL, cw(0, 0, 0, 0, 0, 1, 0, 2'd1));
        wr(A_LOAD, 2); rd(A_CNT, "R7 overwrite"); check("R7 literal", last_rd, 32'd2);
        wr(A_CTRL, cw(1, 0, 0, 0, 0, 1, 0, 2'd1));
        rd(A_CNT, "R4 a"); rd(A_CNT, "R4 b"); rd(A_CNT, "R4 c"); rd(A_CNT, "R4 d");
        check("R4 wrap literal", last_rd, 32'hFFFF_FFFF);

        // R5 reload
        wr(A_CTRL, cw(0, 0, 0, 1, 0, 1, 0, 2'd1));
        wr(A_LOAD, 3);
        wr(A_CTRL, cw(1, 0, 0, 1, 0, 1, 0, 2'd1));
        for (int i = 0; i < 5; i++) rd(A_CNT, "R5 reload");
        check("R5 literal", last_rd, 32'd3);

        // R8/R9/R10: compare at 1 in each pin mode, reload period 4
        wr(A_CMP, 1);
        for (int pm = 1; pm < 4; pm++) begin
            wr(A_CTRL, cw(1, 0, 1, 1, 0, 1, pm[1:0], 2'd2));
            idle(9);
            rd(A_STAT, "R8 flag set");
            wr(A_STAT, 0); rd(A_STAT, "R8 write0 keeps");
            wr(A_STAT, 1); rd(A_STAT, "R8 w1c");
        end
        // mode 0 with silent matches, then back to flip
        wr(A_CTRL, cw(1, 0, 0, 1, 0, 1, 2'd0, 2'd2));
        idle(8);
        wr(A_CTRL, cw(1, 0, 0, 1, 0, 1, 2'd1, 2'd2));
        idle(4);
        // R8 set beats clear: clear written each cycle while matches occur
        for (int i = 0; i < 8; i++) begin wr(A_STAT, 1); rd(A_STAT, "R8 set wins"); end

        // R11 soft reset mid-run with junk bits
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, "R11 ctrl"); rd(A_STAT, "R11 stat"); rd(A_CMP, "R11 cmp");
        rd(A_CNT, "R11 cnt");
        rd(A_LOAD, "R11 load"); check("R11 load literal", last_rd, 32'hFFFF_FFFF);

        // constrained random mix
        for (int i = 0; i < 6000; i++) begin
            int unsigned r = $urandom % 16;
            if (r < 6) begin
                a = 5'($urandom % 6) << 2;
                if ($urandom % 8 == 0) a = 5'($urandom);
                rd(a, "R3 random read");
            end else if (r < 9) begin
                d = $urandom;
                d[15:4] = 12'($urandom % 4);
                d[16] = ($urandom % 50 == 0);
                wr(A_CTRL, d);
            end else if (r < 11) begin
                wr(A_CMP, m_cnt - ($urandom % 12));
            end else if (r < 12) begin
                wr(A_LOAD, ($urandom % 2) ? ($urandom % 40) : $urandom);
            end else if (r < 13) begin
                wr(A_STAT, $urandom);
            end else begin
                idle(1);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule